// File: doc/BRIEF.md
# Parallel-Prefix Ones Ranker and First-Request Arbiter

This block takes an N-bit request vector, qualified by a valid strobe, and produces two results from one pass of parallel-prefix logic. The first result numbers every asserted request bit. Each set bit gets its position among the set bits, counting upward from bit 0 and starting at 1. This value comes from an inclusive running count of the bits. The second result is a one-hot grant for the lowest-indexed asserted request. It is formed by taking, at each position, the OR of all lower positions, inverting it, and masking it with the request. It is not built from a priority encoder.

Both results come from log-depth scans of the Kogge-Stone type, with ceil(log2 N) combining levels. By default the grant's exclusive OR-scan is derived from the running count that the ranker already computes, so the two functions share one network. A parameter can instead select a separate OR-scan network. All outputs are registered once. A small two-state controller tracks whether the output register holds a fresh result. In state IDLE, a cycle with the valid strobe high moves it to LOADED. In state LOADED, a valid cycle keeps it in LOADED and a cycle without valid returns it to IDLE. The output valid flag is high exactly while the controller is in LOADED.

Top module: `scan_ranker`

## Requirements
- R1: For every position i whose request bit was set, the rank field `rank_flat[i*CW +: CW]` (CW = $clog2(N+1)) equals the number of set request bits at indices 0..i, so the lowest set bit has rank 1.
- R2: `rank_ok[i]` equals the request bit i of the captured vector, marking which rank fields are meaningful. Rank fields at unset positions carry no defined value.
- R3: `grant` has at most one bit set.
- R4: When the captured vector is non-zero, `grant` has exactly the bit of the lowest-indexed set request, and no granted bit lies outside the request.
- R5: `total` equals the number of set request bits, and its width CW holds the all-ones count N.
- R6: A cycle with `req_valid` high is reflected at the outputs one clock later, with `out_valid` high in that cycle. `out_valid` is low one clock after a cycle with `req_valid` low.
- R7: While `req_valid` is low, changes on `req_vec` have no effect: rank, qualifier, grant and total keep the last captured result.
- R8: An all-zero captured request gives an all-zero grant and a total of 0.
- R9: While `rst_n` is low, `out_valid`, `rank_ok`, `grant`, `total` and all rank fields are 0.
- R10: The shared-network variant (SHARED_NET=1) and the separate OR-scan variant (SHARED_NET=0) give identical grant, rank and total for the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Qualifies req_vec for capture this cycle |
| req_vec | input | N | Request / data bits, bit 0 lowest index |
| out_valid | output | 1 | High in the cycle after a captured input |
| rank_flat | output | N*CW | Rank of position i in bits [i*CW +: CW] |
| rank_ok | output | N | Per-position qualifier: rank field i is meaningful |
| grant | output | N | One-hot grant of the lowest set request |
| total | output | CW | Count of set request bits |

## Verification
The grant and the rank field of value 1 always come out in the same cycle from the same captured vector. Both must land on the same position, because the shared configuration derives the grant from the running count. The bench provokes this with vectors whose lowest set bit sits at index 0, at the top index, in the middle, and in the dense pattern 0 0 1 0 1 0 0 1 1 1 0. Each case is judged by comparing the grant and every qualified rank field, in that one output cycle, with values computed in the bench. A second instance built with the separate OR-scan must agree bit for bit in the same cycle.

// File: rtl/scan_rank_pkg.sv
package scan_rank_pkg;

    // Output-register occupancy controller
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } out_state_e;

    // Width needed to hold a count from 0 to n inclusive
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/prefix_sum_net.sv
module prefix_sum_net #(
    parameter int N  = 16,
    parameter int CW = 5
) (
    input  logic [N-1:0]    bits,
    output logic [N*CW-1:0] sums_flat
);
    localparam int LEVELS = $clog2(N);

    // Stage l holds, at position i, the sum of bits (i-2^l, i]
    logic [CW-1:0] stage [0:LEVELS][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_seed
        assign stage[0][i] = CW'(bits[i]);
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int DIST = 1 << l;
        for (genvar i = 0; i < N; i++) begin : g_node
            if (i >= DIST) begin : g_add
                assign stage[l+1][i] = stage[l][i] + stage[l][i-DIST];
            end else begin : g_pass
                assign stage[l+1][i] = stage[l][i];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign sums_flat[i*CW +: CW] = stage[LEVELS][i];
    end

endmodule

// File: rtl/prefix_or_net.sv
module prefix_or_net #(
    parameter int N = 16
) (
    input  logic [N-1:0] bits,
    output logic [N-1:0] below_or
);
    localparam int LEVELS = $clog2(N);

    logic stage [0:LEVELS][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_seed
        assign stage[0][i] = bits[i];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int DIST = 1 << l;
        for (genvar i = 0; i < N; i++) begin : g_node
            if (i >= DIST) begin : g_or
                assign stage[l+1][i] = stage[l][i] | stage[l][i-DIST];
            end else begin : g_pass
                assign stage[l+1][i] = stage[l][i];
            end
        end
    end

    // Diminished (exclusive) scan: position i sees positions 0..i-1
    assign below_or[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_shift
        assign below_or[i] = stage[LEVELS][i-1];
    end

endmodule

// File: rtl/scan_ranker.sv
module scan_ranker
    import scan_rank_pkg::*;
#(
    parameter int N          = 16,
    parameter int SHARED_NET = 1,
    parameter int CW         = count_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [N-1:0]    req_vec,
    output logic            out_valid,
    output logic [N*CW-1:0] rank_flat,
    output logic [N-1:0]    rank_ok,
    output logic [N-1:0]    grant,
    output logic [CW-1:0]   total
);

    // ---------------- combinational scans ----------------
    logic [N*CW-1:0] sums_c;
    logic [N-1:0]    below_c;
    logic [N-1:0]    grant_c;

    prefix_sum_net #(.N(N), .CW(CW)) u_sum (
        .bits      (req_vec),
        .sums_flat (sums_c)
    );

    if (SHARED_NET != 0) begin : g_shared
        // Any set bit below i <=> running count at i-1 is non-zero
        assign below_c[0] = 1'b0;
        for (genvar i = 1; i < N; i++) begin : g_dim
            assign below_c[i] = |sums_c[(i-1)*CW +: CW];
        end
    end else begin : g_separate
        prefix_or_net #(.N(N)) u_or (
            .bits     (req_vec),
            .below_or (below_c)
        );
    end

    assign grant_c = req_vec & ~below_c;

    // ---------------- controller ----------------
    out_state_e state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   state_n = req_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_n = req_valid ? ST_LOADED : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // ---------------- output register ----------------
    logic [N*CW-1:0] rank_q;
    logic [N-1:0]    ok_q;
    logic [N-1:0]    grant_q;
    logic [CW-1:0]   total_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q  <= '0;
            ok_q    <= '0;
            grant_q <= '0;
            total_q <= '0;
        end else if (req_valid) begin
            rank_q  <= sums_c;
            ok_q    <= req_vec;
            grant_q <= grant_c;
            total_q <= sums_c[(N-1)*CW +: CW];
        end
    end

    always_comb begin
        out_valid = (state_q == ST_LOADED);
        rank_flat = rank_q;
        rank_ok   = ok_q;
        grant     = grant_q;
        total     = total_q;
    end

    // ---------------- assertions ----------------
    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    assert_grant_in_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q & ~ok_q) == '0);

    assert_grant_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q != '0) |-> (grant_q != '0));

    assert_total_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(total_q) == $countones(ok_q));

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(grant_q) && $stable(total_q) && $stable(ok_q)));

    assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q == '0) |-> (grant_q == '0 && total_q == '0));

endmodule

// File: tb/scan_ranker_tb.sv
module scan_ranker_tb;
    localparam int N  = 16;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [N-1:0] req_vec = '0;

    logic            ov_a, ov_b;
    logic [N*CW-1:0] rk_a, rk_b;
    logic [N-1:0]    ok_a, ok_b, gr_a, gr_b;
    logic [CW-1:0]   tot_a, tot_b;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    scan_ranker #(.N(N), .SHARED_NET(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
        .out_valid(ov_a), .rank_flat(rk_a), .rank_ok(ok_a), .grant(gr_a), .total(tot_a));

    scan_ranker #(.N(N), .SHARED_NET(0)) u_dut_sep (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
        .out_valid(ov_b), .rank_flat(rk_b), .rank_ok(ok_b), .grant(gr_b), .total(tot_b));

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_grant(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
        return '0;
    endfunction

    function automatic logic [CW-1:0] exp_total(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return CW'(c);
    endfunction

    // Compare all qualified rank fields against the running count
    task automatic check_ranks(input logic [N-1:0] v, input string tag);
        int c = 0;
        int bad = -1;
        logic [CW-1:0] got = '0;
        for (int i = 0; i < N; i++) begin
            if (v[i]) begin
                c++;
                if (rk_a[i*CW +: CW] !== CW'(c) && bad < 0) begin
                    bad = i;
                    got = rk_a[i*CW +: CW];
                end
            end
        end
        n_checks++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL R1 %s rank at bit %0d: actual %0d expected %0d",
                     tag, bad, got, exp_rank_at(v, bad));
        end
    endtask

    function automatic int exp_rank_at(input logic [N-1:0] v, input int pos);
        int c = 0;
        for (int i = 0; i <= pos; i++) c += int'(v[i]);
        return c;
    endfunction

    // Apply one valid vector, check outputs one cycle later
    task automatic apply_check(input logic [N-1:0] v, input string tag);
        @(negedge clk);
        req_vec   = v;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6", {tag, " out_valid"}, 128'(ov_a), 128'(1));
        check_ranks(v, tag);
        check("R2", {tag, " rank_ok"}, 128'(ok_a), 128'(v));
        check("R4", {tag, " grant"}, 128'(gr_a), 128'(exp_grant(v)));
        check("R3", {tag, " grant bits"}, 128'($countones(gr_a)), 128'((v != '0) ? 1 : 0));
        check("R5", {tag, " total"}, 128'(tot_a), 128'(exp_total(v)));
        check("R10", {tag, " variant grant"}, 128'(gr_b), 128'(gr_a));
        check("R10", {tag, " variant total/ranks"}, {tot_b, rk_b}, {tot_a, rk_a});
    endtask

    task automatic test_reset;
        check("R9", "reset out_valid", 128'(ov_a), 128'(0));
        check("R9", "reset grant/ok/total", {gr_a, ok_a, tot_a}, '0);
        check("R9", "reset ranks", 128'(rk_a), 128'(0));
    endtask

    task automatic test_example;
        // data bits 0..10 = 0 0 1 0 1 0 0 1 1 1 0 -> ranks 1..5, grant bit 2
        apply_check(16'h0394, "example");
        check("R1", "example rank bit9", 128'(rk_a[9*CW +: CW]), 128'(5));
        check("R4", "example grant bit2", 128'(gr_a), 128'(16'h0004));
    endtask

    task automatic test_empty;
        apply_check('0, "empty");
        check("R8", "empty grant+total", {gr_a, tot_a}, '0);
    endtask

    task automatic test_full;
        apply_check('1, "full");
        check("R5", "full total N", 128'(tot_a), 128'(N));
        check("R1", "full top rank", 128'(rk_a[(N-1)*CW +: CW]), 128'(N));
    endtask

    task automatic test_edges;
        apply_check(16'h8000, "msb only");
        apply_check(16'h0001, "lsb only");
        apply_check(16'hAAAA, "alternating");
        apply_check(16'h8001, "ends");
        apply_check(16'h0FF0, "middle run");
    endtask

    task automatic test_back_to_back;
        @(negedge clk);
        req_vec = 16'h0030; req_valid = 1'b1;
        @(negedge clk);
        check("R4", "b2b first grant", 128'(gr_a), 128'(16'h0010));
        req_vec = 16'h4400;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6", "b2b second valid", 128'(ov_a), 128'(1));
        check("R4", "b2b second grant", 128'(gr_a), 128'(16'h0400));
        check("R5", "b2b second total", 128'(tot_a), 128'(2));
    endtask

    task automatic test_hold;
        apply_check(16'h0120, "hold base");
        @(negedge clk);
        req_valid = 1'b0;
        req_vec   = 16'hFFFF;
        @(negedge clk);
        check("R6", "hold out_valid low", 128'(ov_a), 128'(0));
        check("R7", "hold grant", 128'(gr_a), 128'(16'h0020));
        check("R7", "hold total/ok", {tot_a, ok_a}, {CW'(2), 16'h0120});
        check("R7", "hold ranks", 128'({rk_a[8*CW +: CW], rk_a[5*CW +: CW]}),
              128'({CW'(2), CW'(1)}));
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_example();
        test_empty();
        test_full();
        test_edges();
        test_back_to_back();
        test_hold();
        repeat (2) @(negedge clk);
        report();
    end

endmodule